// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four modem handshake lines: clear-to-send, data-set-ready, ring indicator and carrier detect. It presents them to the processor as one 8-bit status byte. Each line first passes through a two-flop synchroniser. The byte's high nibble shows the synchronised levels. The low nibble holds sticky event flags that record activity on each line since the processor last took the byte.

The processor reads the byte and pulses `rd_stb` in the same cycle. That pulse clears every event flag. An event that is detected in the very cycle of the read still lands in its flag, so no change is lost. While any flag is set and `msi_en` is high, the block raises a registered interrupt request. Bus decode and the ranking of this request against other interrupt sources belong to the surrounding logic.

Top module: `msd_top`

## Requirements
- R1: Status bits 4, 5, 6 and 7 show the levels of `cts_i`, `dsr_i`, `ri_i` and `dcd_i`. Each bit follows its input at the second rising clock edge after the input changes.
- R2: Status bits 0, 1 and 3 are the change flags for CTS, DSR and DCD. A flag is set one clock edge after its level bit in the byte changes in either direction.
- R3: Status bit 2 is set only when the ring level bit falls from 1 to 0, one edge after that fall. A rising ring level leaves bit 2 unchanged.
- R4: Once set, a change flag stays set on every edge where `rd_stb` is low.
- R5: An edge with `rd_stb` high clears all four flags. The exception is a flag whose event is detected at that same edge: that flag is set.
- R6: `irq_o` is registered. After each edge it equals `msi_en` sampled at that edge ANDed with the OR of the flag values loaded at that edge. It falls at the same edge where a read clears the flags.
- R7: While `msi_en` is low, `irq_o` stays low and the flags keep latching events.
- R8: A synchronous high `rst` clears the synchronisers, the levels, all flags and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| cts_i | input | 1 | Clear-to-send level, asynchronous |
| dsr_i | input | 1 | Data-set-ready level, asynchronous |
| ri_i | input | 1 | Ring indicator level, asynchronous |
| dcd_i | input | 1 | Carrier detect level, asynchronous |
| rd_stb | input | 1 | One-cycle pulse marking a processor read of the status byte |
| msi_en | input | 1 | Modem-status interrupt enable |
| status_o | output | 8 | {DCD, RI, DSR, CTS levels, DCD change, ring trailing edge, DSR change, CTS change} |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The lines are driven with isolated single toggles. These show the two-edge level latency and the three-edge flag latency on each bit by itself. A ring pulse with a rise and a later fall shows that bit 2 responds only to the trailing edge. A read placed on the exact edge where a DSR event is detected separates correct merging from a plain clear. Toggling the enable with flags pending shows that masking affects only the request and not the flags. A stretch of simultaneous toggles on all lines, with reads at irregular times, is compared against a delay-line reference on every cycle.

// File: rtl/msd_pkg.sv
package msd_pkg;
  localparam int unsigned LINES = 4;
  localparam int unsigned STAT_W = 2 * LINES;
  // line index inside the level/flag vectors
  typedef enum int unsigned {
    LN_CTS = 0,
    LN_DSR = 1,
    LN_RI  = 2,
    LN_DCD = 3
  } line_e;
  // lines whose flag fires only on a 1->0 transition
  localparam logic [LINES-1:0] TRAIL_ONLY = 4'b0100;
endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/msd_edge.sv
module msd_edge #(
  parameter int unsigned    WIDTH     = 4,
  parameter logic [WIDTH-1:0] FALL_ONLY = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] ev_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
      if (FALL_ONLY[i]) begin : g_fall
        assign ev_o[i] = prev_q[i] & ~lvl_i[i];
      end else begin : g_any
        assign ev_o[i] = prev_q[i] ^ lvl_i[i];
      end
    end
  endgenerate
endmodule

// File: rtl/msd_flags.sv
module msd_flags #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] ev_i,
  input  logic             rd_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] flags_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] flags_q, flags_d;
  logic             irq_q;

  always_comb begin
    flags_d = (rd_i ? '0 : flags_q) | ev_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= en_i & (|flags_d);
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/msd_top.sv
module msd_top
  import msd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cts_i,
  input  logic              dsr_i,
  input  logic              ri_i,
  input  logic              dcd_i,
  input  logic              rd_stb,
  input  logic              msi_en,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  logic [LINES-1:0] raw_w, lvl_w, ev_w, flags_w;

  assign raw_w[LN_CTS] = cts_i;
  assign raw_w[LN_DSR] = dsr_i;
  assign raw_w[LN_RI]  = ri_i;
  assign raw_w[LN_DCD] = dcd_i;

  msd_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_w), .q_o(lvl_w)
  );

  msd_edge #(.WIDTH(LINES), .FALL_ONLY(TRAIL_ONLY)) u_edge (
    .clk(clk), .rst(rst), .lvl_i(lvl_w), .ev_o(ev_w)
  );

  msd_flags #(.WIDTH(LINES)) u_flags (
    .clk(clk), .rst(rst), .ev_i(ev_w), .rd_i(rd_stb), .en_i(msi_en),
    .flags_o(flags_w), .irq_o(irq_o)
  );

  assign status_o = {lvl_w, flags_w};
endmodule

// File: rtl/msd_chk.sv
module msd_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_stb,
  input logic       msi_en,
  input logic [7:0] status_o,
  input logic       irq_o,
  input logic [3:0] ev_w
);
  // R4
  flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> ((status_o[3:0] & $past(status_o[3:0])) == $past(status_o[3:0])));

  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && ev_w == 4'b0000) |=> (status_o[3:0] == 4'b0000));

  // R5
  read_keeps_event_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && ev_w != 4'b0000) |=> (status_o[3:0] == $past(ev_w)));

  // R7
  masked_irq_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(msi_en) |-> !irq_o);

  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (status_o[3:0] != 4'b0000));

  // R3
  ring_trail_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[2]) |-> !$past(status_o[6]));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (status_o[3:0] == 4'b0000 && !irq_o));
endmodule

bind msd_top msd_chk u_chk (
  .clk(clk), .rst(rst), .rd_stb(rd_stb), .msi_en(msi_en),
  .status_o(status_o), .irq_o(irq_o), .ev_w(ev_w)
);

// File: tb/tb_msd_top.sv
module tb_msd_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cts_i = 0, dsr_i = 0, ri_i = 0, dcd_i = 0;
  logic rd_stb = 0, msi_en = 0;
  logic [7:0] status_o;
  logic irq_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  msd_top dut (
    .clk(clk), .rst(rst), .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i),
    .dcd_i(dcd_i), .rd_stb(rd_stb), .msi_en(msi_en),
    .status_o(status_o), .irq_o(irq_o)
  );

  // reference: history of sampled inputs, h[0] newest
  logic [3:0] h [3];
  logic [3:0] mflags;
  logic       mirq;

  always @(posedge clk) begin
    logic [3:0] ev, nf;
    if (rst) begin
      for (int k = 0; k < 3; k++) h[k] = 4'b0;
      mflags = 4'b0;
      mirq   = 1'b0;
    end else begin
      for (int i = 0; i < 4; i++)
        ev[i] = (i == 2) ? (h[2][i] && !h[1][i]) : (h[2][i] != h[1][i]);
      nf     = (rd_stb ? 4'b0 : mflags) | ev;
      mflags = nf;
      mirq   = msi_en && (nf != 4'b0);
      h[2]   = h[1];
      h[1]   = h[0];
      h[0]   = {dcd_i, ri_i, dsr_i, cts_i};
    end
  end

  task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 levels", {5'b0, status_o[7:4]}, {5'b0, h[1]});
      chk("R2 change flags", {6'b0, status_o[3], status_o[1], status_o[0]},
          {6'b0, mflags[3], mflags[1], mflags[0]});
      chk("R3 ring trailing flag", {8'b0, status_o[2]}, {8'b0, mflags[2]});
      chk("R6 irq", {8'b0, irq_o}, {8'b0, mirq});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    chk("R8 reset status", {1'b0, status_o}, 9'h000);
    chk("R8 reset irq", {8'b0, irq_o}, 9'h000);
    rst = 1'b0;
    msi_en = 1'b1;
    cyc(2);
    // R1 / R2: single CTS toggle latency
    cts_i = 1'b1;
    cyc(1);
    chk("R1 cts not yet", {8'b0, status_o[4]}, 9'h000);
    cyc(1);
    chk("R1 cts level", {8'b0, status_o[4]}, 9'h001);
    chk("R2 cts flag not yet", {8'b0, status_o[0]}, 9'h000);
    cyc(1);
    chk("R2 cts flag", {8'b0, status_o[0]}, 9'h001);
    chk("R6 irq raised", {8'b0, irq_o}, 9'h001);
    // R4: sticky while no read
    cyc(6);
    chk("R4 flag held", {8'b0, status_o[0]}, 9'h001);
    // R5 / R6: read clears
    rd_stb = 1'b1; cyc(1); rd_stb = 1'b0;
    chk("R5 cleared", {5'b0, status_o[3:0]}, 9'h000);
    chk("R6 irq dropped", {8'b0, irq_o}, 9'h000);
    // R5: read coinciding with a DSR event
    dsr_i = 1'b1; cyc(2);
    rd_stb = 1'b1; cyc(1); rd_stb = 1'b0;
    chk("R5 same-edge event kept", {5'b0, status_o[3:0]}, 9'h002);
    rd_stb = 1'b1; cyc(1); rd_stb = 1'b0;
    // R3: ring rise does nothing, fall sets bit 2
    ri_i = 1'b1; cyc(5);
    chk("R3 rise ignored", {5'b0, status_o[3:0]}, 9'h000);
    chk("R1 ri level", {8'b0, status_o[6]}, 9'h001);
    ri_i = 1'b0; cyc(3);
    chk("R3 trailing edge", {5'b0, status_o[3:0]}, 9'h004);
    // R7: masked request, flags still latch
    msi_en = 1'b0; cyc(1);
    chk("R7 irq masked", {8'b0, irq_o}, 9'h000);
    dcd_i = 1'b1; cyc(4);
    chk("R7 flag latched while masked", {5'b0, status_o[3:0]}, 9'h00C);
    chk("R7 irq still low", {8'b0, irq_o}, 9'h000);
    msi_en = 1'b1; cyc(1);
    chk("R6 irq on enable", {8'b0, irq_o}, 9'h001);
    // mixed pattern
    for (int t = 0; t < 400; t++) begin
      cts_i  = ((t % 7) == 0) ? ~cts_i : cts_i;
      dsr_i  = ((t % 5) == 0) ? ~dsr_i : dsr_i;
      ri_i   = ((t % 11) < 4);
      dcd_i  = ((t % 13) == 3) ? ~dcd_i : dcd_i;
      rd_stb = ((t % 9) == 4) || ((t % 17) == 0);
      msi_en = ((t % 37) < 30);
      cyc(1);
    end
    rd_stb = 1'b0;
    // R8: reset mid-activity
    rst = 1'b1; cyc(1);
    chk("R8 reset flags", {5'b0, status_o[3:0]}, 9'h000);
    chk("R8 reset irq late", {8'b0, irq_o}, 9'h000);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule